// File: doc/BRIEF.md
# Parallel Bus Block-Copy Engine

This block copies a run of bytes between main DRAM and a ROM-side parallel bus address space. Software programs a DRAM pointer and a ROM-side pointer through a 32-bit word-indexed register port, then writes one of two length registers. The choice of length register selects the direction. The engine walks the run one byte at a time over two simple byte-wide memory ports, one for each space. When the run ends it raises an interrupt line, which software clears through the status register.

The byte count is one more than the written length field. The engine then shortens it by the DRAM pointer's offset inside an 8-byte unit. Both pointers are aligned before use. Each pointer register advances past the run, so back-to-back transfers continue where the last one stopped. Eight byte-wide scratch registers hold bus timing values that software may store and read back. They have no effect on the engine.

Top module: `pbdma_top`

## Requirements
- R1: After reset, every readable register (word indices 0 to 12) reads 0 and `irq` is low.
- R2: A write to word index 2 copies DRAM to ROM. A write to word index 3 copies ROM to DRAM. The nominal byte count is bits [23:0] of the written value plus one. Bytes are copied in ascending address order, so destination byte k equals source byte k.
- R3: The ROM-side start address is the ROM pointer register (word index 1) with bit 0 cleared. The DRAM start address is the DRAM pointer register (word index 0) ANDed with 0x007FFFFE.
- R4: When bits [2:0] of the DRAM start address are nonzero, that value is subtracted from the nominal byte count.
- R5: Once a transfer has been started, each pointer register reads its start address plus the final byte count. The length register that started the transfer reads the final byte count.
- R6: Status (word index 4) reads as follows: bit 0 is transfer active, bits 1 and 2 are always 0, and bit 3 is interrupt pending. Bits above 3 read 0. The `irq` port equals the pending bit.
- R7: The pending bit sets on the clock edge that completes a transfer, and bit 0 clears on that same edge. A status write with bit 1 set clears the pending bit. If a completion and a clear fall on the same edge, the completion wins. A status write with bit 1 clear leaves the pending bit unchanged.
- R8: Word indices 5 to 12 are eight scratch registers. Each keeps only bits [7:0] of a write and reads them back zero-extended. Writing one leaves the others unchanged.
- R9: A transfer of N bytes keeps the active bit at 1 for exactly 2N cycles after the starting write. At most one memory strobe is asserted per cycle. Writes to either length register while the transfer is active are ignored.
- R10: The ROM port address is the current ROM-side address truncated to its low ROM_AW bits, so runs wrap inside the ROM window.
- R11: If the trimmed byte count is zero or less, the final count is 0. No memory strobe is asserted, the active bit never sets, and the pending bit sets on the edge of the starting write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_widx | input | 4 | Register word index for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_widx` (combinational) |
| irq | output | 1 | Interrupt pending |
| dram_addr | output | DRAM_AW | DRAM byte address |
| dram_rd | output | 1 | DRAM read strobe; data is expected on `dram_rdata` one cycle later |
| dram_wr | output | 1 | DRAM write strobe |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte |
| rom_addr | output | ROM_AW | ROM-side byte address |
| rom_rd | output | 1 | ROM-side read strobe; data is expected one cycle later |
| rom_wr | output | 1 | ROM-side write strobe |
| rom_wdata | output | 8 | ROM-side write byte |
| rom_rdata | input | 8 | ROM-side read byte |

## Verification
The bound checker watches several properties on every cycle:
- no more than one memory strobe is asserted at a time;
- the ports stay quiet while idle;
- every read is followed by a write;
- a falling active bit always leaves the interrupt pending;
- an idle-time clear drops the interrupt;
- a length write made while idle always either starts a transfer or raises the interrupt.

Only the bench scenarios can show the rest. That covers the byte-exact data movement in both directions, the alignment and trimming arithmetic, and pointer advance. It also covers the ROM window wrap, the zero-count case, and the exact 2N-cycle length of the active period, which the bench's per-clock model of the interrupt line pins down.

// File: rtl/pbdma_pkg.sv
package pbdma_pkg;
   localparam int unsigned REG_W = 32;
   localparam logic [3:0] IDX_DPTR = 4'd0;
   localparam logic [3:0] IDX_RPTR = 4'd1;
   localparam logic [3:0] IDX_D2R  = 4'd2;
   localparam logic [3:0] IDX_R2D  = 4'd3;
   localparam logic [3:0] IDX_STAT = 4'd4;
   localparam int unsigned STUB_BASE = 5;

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_STORE} eng_state_e;
   typedef enum logic {DIR_D2R = 1'b0, DIR_R2D = 1'b1} dir_e;

   typedef struct packed {
      logic pend;
      logic io_err;
      logic io_busy;
      logic active;
   } stat_t;
endpackage

// File: rtl/pbdma_sizer.sv
module pbdma_sizer #(
   parameter int unsigned LEN_W     = 24,
   parameter logic [31:0] DRAM_MASK = 32'h007F_FFFE,
   localparam int unsigned CNT_W    = LEN_W + 1
) (
   input  logic [31:0]      len_val,
   input  logic [31:0]      dptr,
   input  logic [31:0]      rptr,
   output logic [31:0]      dram_start,
   output logic [31:0]      rom_start,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] nominal;
   logic [CNT_W-1:0] trim;

   always_comb begin
      dram_start = dptr & DRAM_MASK;
      rom_start  = {rptr[31:1], 1'b0};
      nominal    = {1'b0, len_val[LEN_W-1:0]} + CNT_W'(1);
      trim       = CNT_W'(dram_start[2:0]);
      count      = (nominal > trim) ? (nominal - trim) : '0;
   end
endmodule

// File: rtl/pbdma_stubs.sv
module pbdma_stubs #(
   parameter int unsigned N    = 8,
   parameter int unsigned W    = 8,
   parameter int unsigned BASE = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [3:0]  widx,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        hit
);
   logic [W-1:0] rd_vec [N];

   for (genvar gi = 0; gi < N; gi++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                q <= '0;
         else if (we && (widx == 4'(BASE + gi)))    q <= wdata[W-1:0];
      end
      assign rd_vec[gi] = q;
   end

   always_comb begin
      rdata = '0;
      hit   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (widx == 4'(BASE + i)) begin
            hit   = 1'b1;
            rdata = {{(32-W){1'b0}}, rd_vec[i]};
         end
      end
   end
endmodule

// File: rtl/pbdma_engine.sv
module pbdma_engine
   import pbdma_pkg::*;
#(
   parameter int unsigned CNT_W   = 25,
   parameter int unsigned DRAM_AW = 23,
   parameter int unsigned ROM_AW  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  dir_e               dir,
   input  logic [31:0]        dram_base,
   input  logic [31:0]        rom_base,
   input  logic [CNT_W-1:0]   count,
   output logic               active,
   output logic               done,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic               dram_rd,
   output logic               dram_wr,
   output logic [7:0]         dram_wdata,
   input  logic [7:0]         dram_rdata,
   output logic [ROM_AW-1:0]  rom_addr,
   output logic               rom_rd,
   output logic               rom_wr,
   output logic [7:0]         rom_wdata,
   input  logic [7:0]         rom_rdata
);
   eng_state_e       state;
   dir_e             dir_q;
   logic [CNT_W-1:0] idx, total;
   logic [CNT_W-1:0] idx_nx;
   logic [31:0]      d_base, r_base;
   logic [31:0]      d_cur, r_cur;

   assign idx_nx = idx + CNT_W'(1);
   assign d_cur  = d_base + {{(32-CNT_W){1'b0}}, idx};
   assign r_cur  = r_base + {{(32-CNT_W){1'b0}}, idx};
   assign active = (state != ST_IDLE);
   assign done   = (state == ST_STORE) && (idx_nx == total);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         dir_q  <= DIR_D2R;
         idx    <= '0;
         total  <= '0;
         d_base <= '0;
         r_base <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state  <= ST_FETCH;
               dir_q  <= dir;
               idx    <= '0;
               total  <= count;
               d_base <= dram_base;
               r_base <= rom_base;
            end
            ST_FETCH: state <= ST_STORE;
            ST_STORE: begin
               idx   <= idx_nx;
               state <= done ? ST_IDLE : ST_FETCH;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      dram_addr  = d_cur[DRAM_AW-1:0];
      rom_addr   = r_cur[ROM_AW-1:0];
      dram_wdata = rom_rdata;
      rom_wdata  = dram_rdata;
      dram_rd    = (state == ST_FETCH) && (dir_q == DIR_D2R);
      rom_rd     = (state == ST_FETCH) && (dir_q == DIR_R2D);
      rom_wr     = (state == ST_STORE) && (dir_q == DIR_D2R);
      dram_wr    = (state == ST_STORE) && (dir_q == DIR_R2D);
   end
endmodule

// File: rtl/pbdma_top.sv
module pbdma_top
   import pbdma_pkg::*;
#(
   parameter int unsigned DRAM_AW   = 23,
   parameter int unsigned ROM_AW    = 16,
   parameter int unsigned LEN_W     = 24,
   parameter int unsigned STUB_N    = 8,
   parameter int unsigned STUB_W    = 8,
   parameter logic [31:0] DRAM_MASK = 32'h007F_FFFE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [3:0]         reg_widx,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq,
   output logic [DRAM_AW-1:0] dram_addr,
   output logic               dram_rd,
   output logic               dram_wr,
   output logic [7:0]         dram_wdata,
   input  logic [7:0]         dram_rdata,
   output logic [ROM_AW-1:0]  rom_addr,
   output logic               rom_rd,
   output logic               rom_wr,
   output logic [7:0]         rom_wdata,
   input  logic [7:0]         rom_rdata
);
   localparam int unsigned CNT_W = LEN_W + 1;

   if (LEN_W < 4 || LEN_W > 30) begin : g_bad_len
      $error("pbdma_top: LEN_W out of range");
   end
   if (ROM_AW < 1 || ROM_AW > 32 || DRAM_AW < 3 || DRAM_AW > 32) begin : g_bad_aw
      $error("pbdma_top: address width out of range");
   end
   if (STUB_BASE + STUB_N > 16 || STUB_W < 1 || STUB_W > 16) begin : g_bad_stub
      $error("pbdma_top: scratch bank does not fit the index space");
   end

   logic [31:0]      dptr_q, rptr_q, d2r_len_q, r2d_len_q;
   logic             pend_q;
   logic [31:0]      dram_start, rom_start;
   logic [CNT_W-1:0] count;
   logic             eng_active, eng_done;
   logic             len_wr, zero_run, eng_start, clr_req;
   dir_e             dir_sel;
   logic [31:0]      stub_rdata;
   logic             stub_hit;
   stat_t            stat;

   pbdma_sizer #(.LEN_W(LEN_W), .DRAM_MASK(DRAM_MASK)) u_sizer (
      .len_val    (reg_wdata),
      .dptr       (dptr_q),
      .rptr       (rptr_q),
      .dram_start (dram_start),
      .rom_start  (rom_start),
      .count      (count)
   );

   assign dir_sel   = (reg_widx == IDX_R2D) ? DIR_R2D : DIR_D2R;
   assign len_wr    = reg_we && ((reg_widx == IDX_D2R) || (reg_widx == IDX_R2D)) && !eng_active;
   assign zero_run  = (count == '0);
   assign eng_start = len_wr && !zero_run;
   assign clr_req   = reg_we && (reg_widx == IDX_STAT) && reg_wdata[1];

   pbdma_engine #(.CNT_W(CNT_W), .DRAM_AW(DRAM_AW), .ROM_AW(ROM_AW)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (eng_start),
      .dir        (dir_sel),
      .dram_base  (dram_start),
      .rom_base   (rom_start),
      .count      (count),
      .active     (eng_active),
      .done       (eng_done),
      .dram_addr  (dram_addr),
      .dram_rd    (dram_rd),
      .dram_wr    (dram_wr),
      .dram_wdata (dram_wdata),
      .dram_rdata (dram_rdata),
      .rom_addr   (rom_addr),
      .rom_rd     (rom_rd),
      .rom_wr     (rom_wr),
      .rom_wdata  (rom_wdata),
      .rom_rdata  (rom_rdata)
   );

   pbdma_stubs #(.N(STUB_N), .W(STUB_W), .BASE(STUB_BASE)) u_stubs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .widx  (reg_widx),
      .wdata (reg_wdata),
      .rdata (stub_rdata),
      .hit   (stub_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dptr_q    <= '0;
         rptr_q    <= '0;
         d2r_len_q <= '0;
         r2d_len_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         if (len_wr) begin
            dptr_q <= dram_start + {{(32-CNT_W){1'b0}}, count};
            rptr_q <= rom_start + {{(32-CNT_W){1'b0}}, count};
            if (dir_sel == DIR_R2D) r2d_len_q <= {{(32-CNT_W){1'b0}}, count};
            else                    d2r_len_q <= {{(32-CNT_W){1'b0}}, count};
         end else if (reg_we && reg_widx == IDX_DPTR) begin
            dptr_q <= reg_wdata;
         end else if (reg_we && reg_widx == IDX_RPTR) begin
            rptr_q <= reg_wdata;
         end
         if (eng_done || (len_wr && zero_run)) pend_q <= 1'b1;
         else if (clr_req)                     pend_q <= 1'b0;
      end
   end

   assign irq = pend_q;

   always_comb begin
      stat = '{pend: pend_q, io_err: 1'b0, io_busy: 1'b0, active: eng_active};
      unique case (reg_widx)
         IDX_DPTR: reg_rdata = dptr_q;
         IDX_RPTR: reg_rdata = rptr_q;
         IDX_D2R:  reg_rdata = d2r_len_q;
         IDX_R2D:  reg_rdata = r2d_len_q;
         IDX_STAT: reg_rdata = {28'd0, stat};
         default:  reg_rdata = stub_hit ? stub_rdata : 32'd0;
      endcase
   end
endmodule

// File: rtl/pbdma_chk.sv
module pbdma_chk
   import pbdma_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic [3:0]  reg_widx,
   input logic [31:0] reg_wdata,
   input logic        irq,
   input logic        active,
   input logic        dram_rd,
   input logic        dram_wr,
   input logic        rom_rd,
   input logic        rom_wr
);
   a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dram_rd, dram_wr, rom_rd, rom_wr}));

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !(dram_rd || dram_wr || rom_rd || rom_wr));

   a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_rd || rom_rd) |=> (dram_wr || rom_wr));

   a_r7_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> irq);

   a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_widx == IDX_STAT && reg_wdata[1] && !active) |=> !irq);

   a_r2_start_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && (reg_widx == IDX_D2R || reg_widx == IDX_R2D) && !active) |=> (active || irq));
endmodule

bind pbdma_top pbdma_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_widx  (reg_widx),
   .reg_wdata (reg_wdata),
   .irq       (irq),
   .active    (eng_active),
   .dram_rd   (dram_rd),
   .dram_wr   (dram_wr),
   .rom_rd    (rom_rd),
   .rom_wr    (rom_wr)
);

// File: tb/tb_pbdma_top.sv
module tb_pbdma_top;
   localparam int ROM_AW  = 10;
   localparam int DRAM_AW = 23;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_we = 1'b0;
   logic [3:0]        reg_widx = 4'd0;
   logic [31:0]       reg_wdata = 32'd0;
   logic [31:0]       reg_rdata;
   logic              irq;
   logic [DRAM_AW-1:0] dram_addr;
   logic              dram_rd, dram_wr;
   logic [7:0]        dram_wdata;
   logic [7:0]        dram_rdata = 8'd0;
   logic [ROM_AW-1:0] rom_addr;
   logic              rom_rd, rom_wr;
   logic [7:0]        rom_wdata;
   logic [7:0]        rom_rdata = 8'd0;

   always #4 clk = ~clk;

   pbdma_top #(.DRAM_AW(DRAM_AW), .ROM_AW(ROM_AW)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_widx(reg_widx),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .dram_addr(dram_addr), .dram_rd(dram_rd), .dram_wr(dram_wr),
      .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
      .rom_addr(rom_addr), .rom_rd(rom_rd), .rom_wr(rom_wr),
      .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
   );

   logic [7:0] dmem [0:4095];
   logic [7:0] rmem [0:1023];

   function automatic logic [7:0] dpat(int i); return 8'((i * 7 + 3) & 255); endfunction
   function automatic logic [7:0] rpat(int i); return 8'((i * 13 + 90) & 255); endfunction

   initial begin
      for (int i = 0; i < 4096; i++) dmem[i] = dpat(i);
      for (int i = 0; i < 1024; i++) rmem[i] = rpat(i);
   end

   always @(posedge clk) begin
      if (dram_rd) dram_rdata <= dmem[dram_addr[11:0]];
      if (dram_wr) dmem[dram_addr[11:0]] <= dram_wdata;
      if (rom_rd)  rom_rdata <= rmem[rom_addr];
      if (rom_wr)  rmem[rom_addr] <= rom_wdata;
   end

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference for the interrupt line, compared every clock
   int          m_busy = 0;
   bit          m_irq = 0;
   logic [31:0] m_dptr = 0;
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         m_busy = 0; m_irq = 0; m_dptr = 0;
      end else begin
         bit set_i, clr_i;
         set_i = 0; clr_i = 0;
         if (reg_we && reg_widx == 4'd0) m_dptr = reg_wdata;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) set_i = 1;
         end else if (reg_we && (reg_widx == 4'd2 || reg_widx == 4'd3)) begin
            logic [31:0] ds;
            int cnt;
            ds  = m_dptr & 32'h007F_FFFE;
            cnt = int'(reg_wdata[23:0]) + 1 - int'(ds[2:0]);
            if (cnt < 0) cnt = 0;
            m_dptr = ds + 32'(cnt);
            if (cnt == 0) set_i = 1;
            else m_busy = 2 * cnt;
         end
         if (reg_we && reg_widx == 4'd4 && reg_wdata[1]) clr_i = 1;
         if (set_i) m_irq = 1;
         else if (clr_i) m_irq = 0;
         check("R7/R9 irq timing", {31'd0, irq}, {31'd0, m_irq});
      end
   end

   task automatic wr(logic [3:0] idx, logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b1; reg_widx = idx; reg_wdata = val;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] idx, output logic [31:0] val);
      @(negedge clk);
      reg_we = 1'b0; reg_widx = idx;
      #1 val = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int k = 0; k < 5000; k++) begin
         rd(4'd4, s);
         if (s[0] == 1'b0) break;
      end
   endtask

   initial begin
      logic [31:0] v;
      logic [7:0]  keep;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int i = 0; i <= 12; i++) begin
         rd(4'(i), v);
         check("R1 reset register", v, 32'd0);
      end
      check("R1 irq low", {31'd0, irq}, 32'd0);

      // R8: scratch registers
      wr(4'd8, 32'hABCD_1234);
      rd(4'd8, v);  check("R8 keeps low byte", v, 32'h34);
      rd(4'd7, v);  check("R8 neighbour untouched", v, 32'd0);
      wr(4'd12, 32'h0000_01FF);
      rd(4'd12, v); check("R8 last slot", v, 32'hFF);
      rd(4'd8, v);  check("R8 first write kept", v, 32'h34);

      // R2/R3/R5: ROM->DRAM, 16 bytes, odd ROM pointer
      wr(4'd0, 32'h0000_0100);
      wr(4'd1, 32'h0000_0201);
      keep = dmem[16'h110];
      wr(4'd3, 32'hFF00_000F);
      rd(4'd4, v);  check("R6 active while running", v, 32'h1);
      wr(4'd2, 32'h0000_0004);       // R9: ignored while active
      rd(4'd4, v);  check("R7 clear while running keeps active", v & 32'h1, 32'h1);
      wait_idle();
      rd(4'd4, v);  check("R6 status after completion", v, 32'h8);
      check("R6 irq port", {31'd0, irq}, 32'd1);
      for (int i = 0; i < 16; i++)
         check("R2 ROM->DRAM byte", {24'd0, dmem[12'h100 + i]}, {24'd0, rpat(16'h200 + i)});
      check("R2 no overrun", {24'd0, dmem[12'h110]}, {24'd0, keep});
      rd(4'd0, v);  check("R5 DRAM pointer advanced", v, 32'h110);
      rd(4'd1, v);  check("R3/R5 ROM pointer aligned+advanced", v, 32'h210);
      rd(4'd3, v);  check("R5 length holds count", v, 32'd16);
      rd(4'd2, v);  check("R9 length write ignored while active", v, 32'd0);

      // R7: clear semantics
      wr(4'd4, 32'h0000_0001);
      check("R7 write without bit1 keeps pending", {31'd0, irq}, 32'd1);
      wr(4'd4, 32'h0000_0002);
      check("R7 clear", {31'd0, irq}, 32'd0);

      // R3/R4: DRAM->ROM with misaligned DRAM pointer
      wr(4'd0, 32'h8000_0305);
      wr(4'd1, 32'h0000_0051);
      wr(4'd2, 32'h0000_0009);
      wait_idle();
      for (int i = 0; i < 6; i++)
         check("R4 DRAM->ROM trimmed byte", {24'd0, rmem[10'h50 + i]}, {24'd0, dpat(12'h304 + i)});
      check("R4 trimmed run stops", {24'd0, rmem[10'h56]}, {24'd0, rpat(10'h56)});
      rd(4'd0, v);  check("R3/R5 DRAM pointer masked+advanced", v, 32'h30A);
      rd(4'd1, v);  check("R5 ROM pointer", v, 32'h56);
      rd(4'd2, v);  check("R4 trimmed count", v, 32'd6);
      wr(4'd4, 32'h2);

      // R10: ROM window wrap
      wr(4'd0, 32'h0000_0400);
      wr(4'd1, 32'h0000_03FE);
      wr(4'd3, 32'h0000_0003);
      wait_idle();
      for (int i = 0; i < 4; i++)
         check("R10 wrapped ROM byte", {24'd0, dmem[12'h400 + i]}, {24'd0, rpat((10'h3FE + i) & 10'h3FF)});
      rd(4'd1, v);  check("R10 pointer not wrapped", v, 32'h402);
      wr(4'd4, 32'h2);

      // R11: trimmed to nothing
      wr(4'd0, 32'h0000_0007);
      wr(4'd1, 32'h0000_0020);
      keep = dmem[6];
      wr(4'd3, 32'h0000_0003);
      rd(4'd4, v);  check("R11 completes at once", v, 32'h8);
      rd(4'd3, v);  check("R11 zero count", v, 32'd0);
      rd(4'd0, v);  check("R11 DRAM pointer masked", v, 32'h6);
      rd(4'd1, v);  check("R11 ROM pointer", v, 32'h20);
      check("R11 no data moved", {24'd0, dmem[6]}, {24'd0, keep});
      wr(4'd4, 32'h2);
      repeat (4) @(negedge clk);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_cmp++; n_bad++;
         $display("FAIL R9 watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule